// File: doc/BRIEF.md
# Trace Clock Generator

This block derives the clock that paces trace messages leaving a debug port toward an external tool. The clock comes from the system clock and runs at one of four rates, chosen by a 3-bit select field: the full system rate, or the system rate divided by 2, 4 or 8. An enable bit starts and stops the clock. A separate gating bit lets the clock park low whenever the trace port is switched on but has nothing to send. The gating bit comes from a register that resets to 0, so gating is off after reset.

In full-rate mode the system clock passes through a gate that opens and closes only while the system clock is low. In the divided modes a toggle counter produces a clock with a 50% duty cycle. Changes to the rate or the enable wait for the start of a low phase of the trace clock, so every high phase already under way runs to its full length. When gating releases, the divider restarts from a cleared count in the low phase. The block also drives a one-cycle strobe in the system clock domain for each rising edge of the trace clock, for logic that works beside the trace clock.

Top module: `trace_clk_gen`

## Requirements
- R1: During reset and after reset, while clk_en_i is 0, trace_clk_o and edge_en_o stay 0.
- R2: With clk_en_i = 1 and div_sel_i = 0, 1, 2 or 3, trace_clk_o makes 64, 32, 16 or 8 rising edges per 64 system cycles (divide by 1, 2, 4, 8).
- R3: div_sel_i values 4 to 7 behave as divide by 8: 8 rising edges per 64 system cycles.
- R4: In the divided modes trace_clk_o is high for exactly half of each period: 32 of 64 system cycles, in both halves of the system clock.
- R5: With clk_en_i = 0, trace_clk_o stays 0 and edge_en_o produces no pulses, whatever div_sel_i is.
- R6: With gate_en_i = 1, port_en_i = 1, port_busy_i = 0 and msg_pend_i = 0, trace_clk_o is held at 0 and edge_en_o stays 0. If any one of port_en_i = 0, port_busy_i = 1 or msg_pend_i = 1 holds, the clock runs.
- R7: With gate_en_i = 0, an idle port does not stop the clock.
- R8: A change of div_sel_i takes effect at the next falling edge of trace_clk_o. A high phase under way keeps its old length, and the first low phase after the change has the new length.
- R9: When gating releases in divide-by-N mode, the first rising edge of trace_clk_o comes at the (1 + N/2)-th system clock edge after the release. That is the 5th edge for divide by 8 and the 2nd edge for divide by 2.
- R10: edge_en_o is high for one system cycle for each rising edge of trace_clk_o. It is high in the system cycle that starts at that rising edge.
- R11: In full-rate mode trace_clk_o is high in the high half and low in the low half of every system clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_sel_i | input | 3 | Rate select: 0 full, 1 half, 2 quarter, 3 to 7 eighth |
| clk_en_i | input | 1 | Trace clock enable |
| gate_en_i | input | 1 | Allows gating while the port is idle |
| port_en_i | input | 1 | Trace port is enabled |
| port_busy_i | input | 1 | Trace port is transmitting |
| msg_pend_i | input | 1 | A trace client has a pending message |
| trace_clk_o | output | 1 | Trace clock |
| edge_en_o | output | 1 | One-cycle strobe per trace clock rising edge |

## Verification
A rate change and a gating release can reach the divider in the same cycle. Gating holds the clock low, and that low level counts as a low phase boundary, so the new rate must be taken before counting resumes. The bench runs divide by 8 under gating, then changes the select to divide by 2 and drops gate_en_i in one write. It expects the first rising edge at the 2nd system edge and then a 1-cycle low phase, which is the divide-by-2 timing and not divide-by-8 timing. A second case changes the rate while a high phase is under way. It checks that the old high phase runs its full 4 cycles before the new 1-cycle phases begin.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  parameter int unsigned SEL_W   = 3;
  parameter int unsigned LOG_MAX = 3;
  localparam int unsigned RATIO_W = $clog2(LOG_MAX + 1);
  localparam int unsigned CNT_W   = (LOG_MAX > 1) ? LOG_MAX - 1 : 1;

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    logic   en;
    ratio_t ratio;
  } cfg_t;

  // reserved codes clamp to the slowest rate
  function automatic ratio_t sel_to_ratio(logic [SEL_W-1:0] sel);
    if (sel > SEL_W'(LOG_MAX)) return ratio_t'(LOG_MAX);
    return ratio_t'(sel);
  endfunction

  // last count of a half period for ratio r (divide by 2**r)
  function automatic logic [CNT_W-1:0] half_last(ratio_t r);
    logic [CNT_W:0] v;
    if (r == '0) return '0;
    v = ((CNT_W+1)'(1) << (r - ratio_t'(1))) - (CNT_W+1)'(1);
    return v[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/tcg_idle_detect.sv
module tcg_idle_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_en_i,
  input  logic port_en_i,
  input  logic port_busy_i,
  input  logic msg_pend_i,
  output logic gated_o
);
  logic gated_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gated_q <= 1'b0;
    else         gated_q <= gate_en_i & port_en_i & ~port_busy_i & ~msg_pend_i;
  end

  assign gated_o = gated_q;
endmodule

// File: rtl/tcg_divider.sv
module tcg_divider
  import tcg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             clk_en_i,
  input  logic             gated_i,
  output logic             div_o,
  output logic             rise_o,
  output logic             full_run_o,
  output logic [CNT_W-1:0] cnt_o,
  output ratio_t           ratio_o
);
  cfg_t             cfg_q, cfg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             div_q, div_d;
  logic             div_mode, at_last, fall, idle, load;

  assign div_mode = cfg_q.en && (cfg_q.ratio != '0);
  assign at_last  = (cnt_q == half_last(cfg_q.ratio));
  assign fall     = div_q && at_last && !gated_i;
  assign idle     = !div_q && (!div_mode || gated_i);
  // new settings only at the start of a low phase or while stopped
  assign load     = fall || idle;

  always_comb begin
    cfg_d = cfg_q;
    cnt_d = cnt_q;
    div_d = div_q;
    if (load) begin
      cfg_d.en    = clk_en_i;
      cfg_d.ratio = sel_to_ratio(div_sel_i);
      cnt_d       = '0;
      div_d       = 1'b0;
    end else if (gated_i) begin
      cnt_d = '0;
      div_d = 1'b0;
    end else if (at_last) begin
      cnt_d = '0;
      div_d = ~div_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign div_o      = div_q;
  assign rise_o     = !div_q && div_d;
  assign full_run_o = cfg_q.en && (cfg_q.ratio == '0) && !gated_i;
  assign cnt_o      = cnt_q;
  assign ratio_o    = cfg_q.ratio;
endmodule

// File: rtl/tcg_full_gate.sv
module tcg_full_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic gate_o,
  output logic clk_o
);
  logic gate_q;

  // gate state moves only while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= run_i;
  end

  assign gate_o = gate_q;
  assign clk_o  = clk_i & gate_q;
endmodule

// File: rtl/trace_clk_gen.sv
module trace_clk_gen
  import tcg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             clk_en_i,
  input  logic             gate_en_i,
  input  logic             port_en_i,
  input  logic             port_busy_i,
  input  logic             msg_pend_i,
  output logic             trace_clk_o,
  output logic             edge_en_o
);
  logic             gated;
  logic             div_clk, div_rise, full_run, full_gate, full_clk;
  logic [CNT_W-1:0] div_cnt;
  ratio_t           div_ratio;
  logic             edge_q;

  tcg_idle_detect u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gate_en_i  (gate_en_i),
    .port_en_i  (port_en_i),
    .port_busy_i(port_busy_i),
    .msg_pend_i (msg_pend_i),
    .gated_o    (gated)
  );

  tcg_divider u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_sel_i (div_sel_i),
    .clk_en_i  (clk_en_i),
    .gated_i   (gated),
    .div_o     (div_clk),
    .rise_o    (div_rise),
    .full_run_o(full_run),
    .cnt_o     (div_cnt),
    .ratio_o   (div_ratio)
  );

  tcg_full_gate u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (full_run),
    .gate_o(full_gate),
    .clk_o (full_clk)
  );

  // full_gate at a rising edge means that edge reached the output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_q <= 1'b0;
    else         edge_q <= div_rise | full_gate;
  end

  assign trace_clk_o = full_clk | div_clk;
  assign edge_en_o   = edge_q;
endmodule

// File: rtl/trace_clk_gen_checker.sv
module trace_clk_gen_checker
  import tcg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             div_i,
  input logic             gated_i,
  input logic             edge_en_i,
  input logic [CNT_W-1:0] cnt_i,
  input ratio_t           ratio_i
);
  assert_edge_on_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_i) |-> edge_en_i);

  assert_gated_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gated_i |=> !div_i);

  assert_change_in_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_i) |-> !div_i);

  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= half_last(ratio_i));
endmodule

bind trace_clk_gen trace_clk_gen_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .div_i    (div_clk),
  .gated_i  (gated),
  .edge_en_i(edge_en_o),
  .cnt_i    (div_cnt),
  .ratio_i  (div_ratio)
);

// File: tb/trace_clk_gen_bench.sv
module trace_clk_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic       clk_en = 1'b1;
  logic       gate_en = 1'b0;
  logic       port_en = 1'b0;
  logic       port_busy = 1'b0;
  logic       msg_pend = 1'b0;
  logic       trace_clk;
  logic       edge_en;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit meas_on = 1'b0;
  int rise_cnt = 0;

  trace_clk_gen u_trace_clk_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .div_sel_i  (div_sel),
    .clk_en_i   (clk_en),
    .gate_en_i  (gate_en),
    .port_en_i  (port_en),
    .port_busy_i(port_busy),
    .msg_pend_i (msg_pend),
    .trace_clk_o(trace_clk),
    .edge_en_o  (edge_en)
  );

  always #4 clk = ~clk;

  always @(posedge trace_clk) if (meas_on) rise_cnt++;

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] sel;
    logic       en, gate, port, busy, pend;
    logic [7:0] rises, edges, hi_hi, hi_lo;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd11, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd64, 8'd64, 8'd64, 8'd0 }, // R11 R2 full
    '{4'd2,  3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd32, 8'd32, 8'd32, 8'd32}, // R2 R4 /2
    '{4'd2,  3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd16, 8'd16, 8'd32, 8'd32}, // R2 /4
    '{4'd2,  3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8,  8'd8,  8'd32, 8'd32}, // R2 /8
    '{4'd3,  3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8,  8'd8,  8'd32, 8'd32}, // R3
    '{4'd3,  3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8,  8'd8,  8'd32, 8'd32}, // R3
    '{4'd3,  3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8,  8'd8,  8'd32, 8'd32}, // R3
    '{4'd3,  3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8,  8'd8,  8'd32, 8'd32}, // R3
    '{4'd5,  3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd0,  8'd0,  8'd0 }, // R5
    '{4'd6,  3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0,  8'd0,  8'd0,  8'd0 }, // R6 gated
    '{4'd6,  3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd16, 8'd16, 8'd32, 8'd32}, // R6 busy
    '{4'd6,  3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd16, 8'd16, 8'd32, 8'd32}, // R6 pending
    '{4'd6,  3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd16, 8'd16, 8'd32, 8'd32}, // R6 port off
    '{4'd7,  3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd16, 8'd16, 8'd32, 8'd32}, // R7
    '{4'd6,  3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0,  8'd0,  8'd0,  8'd0 }  // R6 full gated
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // returns at 1 ns after a rising system edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic measure(output int hh, output int hl, output int ed, output int rs);
    hh = 0; hl = 0; ed = 0;
    rise_cnt = 0;
    meas_on = 1'b1;
    for (int i = 0; i < 64; i++) begin
      hh += int'(trace_clk);
      ed += int'(edge_en);
      #5;
      hl += int'(trace_clk);
      tick();
    end
    meas_on = 1'b0;
    rs = rise_cnt;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int hh, hl, ed, rs, k, runs;
    vec_t v;

    // R1: reset dominates an enabled full-rate request
    runs = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      runs += int'(trace_clk) + int'(edge_en);
    end
    chk("R1 reset", runs, 0);
    #1 clk_en = 1'b0;
    rst_n = 1'b1;
    runs = 0;
    for (int i = 0; i < 12; i++) begin
      tick();
      runs += int'(trace_clk) + int'(edge_en);
    end
    chk("R1 after reset", runs, 0);

    for (int n = 0; n < NV; n++) begin
      v = VECS[n];
      #1;
      div_sel = v.sel; clk_en = v.en; gate_en = v.gate;
      port_en = v.port; port_busy = v.busy; msg_pend = v.pend;
      settle(24);
      measure(hh, hl, ed, rs);
      chk($sformatf("R%0d vec%0d rises", v.req, n), rs, int'(v.rises));
      chk($sformatf("R10 R%0d vec%0d edges", v.req, n), ed, int'(v.edges));
      chk($sformatf("R4 R%0d vec%0d high half", v.req, n), hh, int'(v.hi_hi));
      chk($sformatf("R4 R%0d vec%0d low half", v.req, n), hl, int'(v.hi_lo));
    end

    // R9: release of gating at divide by 8
    #1;
    div_sel = 3'd3; clk_en = 1'b1; gate_en = 1'b1; port_en = 1'b1;
    port_busy = 1'b0; msg_pend = 1'b0;
    settle(24);
    #1 gate_en = 1'b0;
    k = 0;
    do begin tick(); k++; end while (!trace_clk && k < 20);
    chk("R9 first rise /8", k, 5);
    chk("R10 strobe at rise", int'(edge_en), 1);
    tick();
    chk("R10 strobe one cycle", int'(edge_en), 0);

    // same-cycle rate change and gating release
    #1 gate_en = 1'b1;
    settle(24);
    #1 begin div_sel = 3'd1; gate_en = 1'b0; end
    k = 0;
    do begin tick(); k++; end while (!trace_clk && k < 20);
    chk("R9 R8 first rise /2 after release", k, 2);
    tick();
    chk("R9 following low", int'(trace_clk), 0);
    tick();
    chk("R9 following high", int'(trace_clk), 1);

    // R8: rate change during a /8 high phase
    #1 div_sel = 3'd3;
    settle(24);
    k = 0;
    do begin tick(); k++; end while (trace_clk && k < 40);
    do begin tick(); k++; end while (!trace_clk && k < 40);
    #1 div_sel = 3'd1;
    runs = 1;
    for (int i = 0; i < 12 && trace_clk; i++) begin tick(); if (trace_clk) runs++; end
    chk("R8 old high phase kept", runs, 4);
    runs = 1;
    for (int i = 0; i < 12 && !trace_clk; i++) begin tick(); if (!trace_clk) runs++; end
    chk("R8 new low phase", runs, 1);
    runs = 1;
    for (int i = 0; i < 12 && trace_clk; i++) begin tick(); if (trace_clk) runs++; end
    chk("R8 new high phase", runs, 1);

    finish_run();
  end
endmodule